// File: doc/BRIEF.md
# Legacy memory region steering decoder

This block steers every memory access that falls in the first megabyte of the address space to one of three targets: DRAM with reads and writes, DRAM with writes dropped (shadowed read-only), or the PCI side. The choice comes from a set of programmable per-segment attribute bytes and from a system-management RAM control byte. Both are loaded through a byte-wide configuration write port. A system-management mode input can open the video-range window to DRAM.

The decode is purely combinational from the access address, the write strobe, the mode input and the registered configuration. Only the configuration bytes and a memory-size register are clocked. The size register is loaded once after reset from a size input given in megabytes. It reports the installed memory in 8 MB units, saturating at 255. Accesses below the video window or above the first megabyte always go to DRAM.

Top module: `legacy_steer_top`

## Requirements
- R1: After reset every attribute byte (offsets 0x59 to 0x5F) is 0x00 and the SMRAM control byte (offset 0x72) is 0x02, so every access from 0xA0000 to 0xFFFFF goes to PCI, whatever the mode input.
- R2: `tgt_sel` encodes DRAM as 2'b00, read-only DRAM as 2'b01 and PCI as 2'b10. Any address below 0xA0000, or with any bit above bit 19 set, gives DRAM with `wr_block` low.
- R3: Segment i (0 to 11) spans 16 KB from 0xC0000 + i*0x4000. Its 2-bit attribute is bits [4*(i%2)+1 : 4*(i%2)] of the byte at offset 0x5A + i/2.
- R4: The range 0xF0000 to 0xFFFFF uses bits [5:4] of the byte at offset 0x59.
- R5: An attribute of 3 gives DRAM. An attribute of 1 gives read-only DRAM, with `wr_block` high exactly when the access is a write. Attributes 0 and 2 give PCI. `wr_block` is never high outside these cases.
- R6: The window 0xA0000 to 0xBFFFF gives DRAM when bit 6 of the SMRAM control byte is set, or when bit 3 is set and `smm_active` is high. In all other cases it gives PCI.
- R7: Configuration writes to any offset other than 0x59 to 0x5F and 0x72 change no steering result.
- R8: A configuration write changes the steering from the cycle after its clock edge. The decode follows address, write strobe and mode input in the same cycle.
- R9: On the first clock after reset release, `dram_units` loads min(floor(size_mb/8), 255). It reads 0 during reset and does not change again until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_addr | input | ADDR_W | Access address |
| acc_write | input | 1 | 1 for a write access, 0 for a read |
| smm_active | input | 1 | System-management mode active |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_off | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| size_mb | input | SIZE_W | Installed memory size in MB |
| tgt_sel | output | 2 | Steering target |
| wr_block | output | 1 | Write must be suppressed |
| dram_units | output | 8 | Memory size in 8 MB units, clamped |

## Verification
The steering outputs are combinational. Each one is due in the same cycle its address, strobe and mode inputs are applied, so the bench drives at the falling edge and compares shortly after. A configuration byte is due one rising edge after its write strobe. The bench's reference model therefore applies a write only at the rising edge that captures it, and the compare in the write's own cycle still expects the old mapping. The size register is due at the first rising edge after reset release and is compared on every cycle after that, including while the size input changes.

// File: rtl/legacy_steer_pkg.sv
package legacy_steer_pkg;
  typedef enum logic [1:0] {
    TGT_DRAM    = 2'b00,
    TGT_DRAM_RO = 2'b01,
    TGT_PCI     = 2'b10
  } tgt_e;

  localparam int unsigned ATTR_BASE   = 8'h59;
  localparam int unsigned ATTR_BYTES  = 7;
  localparam int unsigned SMRAM_OFF   = 8'h72;
  localparam logic [7:0]  SMRAM_RESET = 8'h02;
  localparam int unsigned NUM_SEG     = 12;
  localparam int unsigned SEG_PAGE0   = 48;  // 0xC0000 >> 14
  localparam int unsigned VGA_PAGE0   = 40;  // 0xA0000 >> 14
  localparam int unsigned HIGH_PAGE0  = 60;  // 0xF0000 >> 14
  localparam int unsigned SMRAM_SMM_BIT  = 3;
  localparam int unsigned SMRAM_OPEN_BIT = 6;
endpackage

// File: rtl/legacy_cfg_regs.sv
module legacy_cfg_regs
  import legacy_steer_pkg::*;
#(
  parameter int unsigned SIZE_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [7:0]                cfg_off,
  input  logic [7:0]                cfg_wdata,
  input  logic [SIZE_W-1:0]         size_mb,
  output logic [ATTR_BYTES*8-1:0]   attr_flat,
  output logic [7:0]                smram,
  output logic [7:0]                dram_units,
  output logic                      size_loaded
);
  localparam int unsigned WIDE_W = SIZE_W + 8;

  logic [ATTR_BYTES*8-1:0] attr_q, attr_d;
  logic [7:0]              smram_q, smram_d;
  logic [7:0]              units_q, units_calc;
  logic                    loaded_q;
  logic [WIDE_W-1:0]       size_wide;
  logic                    cfg_en;

  // next state of the configuration bytes
  always_comb begin
    attr_d  = attr_q;
    smram_d = smram_q;
    for (int b = 0; b < int'(ATTR_BYTES); b++) begin
      if (cfg_off == 8'(ATTR_BASE + b))
        attr_d[b*8 +: 8] = cfg_wdata;
    end
    if (cfg_off == 8'(SMRAM_OFF))
      smram_d = cfg_wdata;
  end

  assign cfg_en = cfg_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      attr_q  <= '0;
      smram_q <= SMRAM_RESET;
    end else if (cfg_en) begin
      attr_q  <= attr_d;
      smram_q <= smram_d;
    end
  end

  // size in 8 MB units, saturated to one byte
  always_comb begin
    size_wide  = {8'b0, size_mb} >> 3;
    units_calc = (size_wide > WIDE_W'(255)) ? 8'hFF : size_wide[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      units_q  <= '0;
      loaded_q <= 1'b0;
    end else if (!loaded_q) begin
      units_q  <= units_calc;
      loaded_q <= 1'b1;
    end
  end

  assign attr_flat   = attr_q;
  assign smram       = smram_q;
  assign dram_units  = units_q;
  assign size_loaded = loaded_q;
endmodule

// File: rtl/legacy_addr_decode.sv
module legacy_addr_decode
  import legacy_steer_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0]         acc_addr,
  input  logic                      acc_write,
  input  logic                      smm_active,
  input  logic [ATTR_BYTES*8-1:0]   attr_flat,
  input  logic [7:0]                smram,
  output logic [1:0]                tgt_sel,
  output logic                      wr_block
);
  logic [1:0] seg_attr [NUM_SEG];
  logic [5:0] page;
  logic [3:0] seg_idx;
  logic       in_low;
  logic       use_attr;
  logic [1:0] sel_attr;
  logic       vga_open;
  tgt_e       tgt;

  // one 2-bit field per 16 KB segment, two fields per byte
  for (genvar g = 0; g < int'(NUM_SEG); g++) begin : g_seg
    assign seg_attr[g] = attr_flat[8*(1 + g/2) + 4*(g%2) +: 2];
  end

  assign page     = acc_addr[19:14];
  assign seg_idx  = 4'(page - 6'(SEG_PAGE0));
  assign in_low   = (acc_addr[ADDR_W-1:20] == '0);
  assign vga_open = smram[SMRAM_OPEN_BIT] | (smram[SMRAM_SMM_BIT] & smm_active);

  always_comb begin
    use_attr = 1'b0;
    sel_attr = 2'b00;
    tgt      = TGT_DRAM;
    if (in_low && page >= 6'(VGA_PAGE0)) begin
      if (page < 6'(SEG_PAGE0)) begin
        tgt = vga_open ? TGT_DRAM : TGT_PCI;
      end else begin
        use_attr = 1'b1;
        if (page < 6'(HIGH_PAGE0)) sel_attr = seg_attr[seg_idx];
        else                       sel_attr = attr_flat[5:4];
        case (sel_attr)
          2'b11:   tgt = TGT_DRAM;
          2'b01:   tgt = TGT_DRAM_RO;
          default: tgt = TGT_PCI;
        endcase
      end
    end
  end

  assign tgt_sel  = tgt;
  assign wr_block = use_attr & (sel_attr == 2'b01) & acc_write;
endmodule

// File: rtl/legacy_steer_top.sv
module legacy_steer_top
  import legacy_steer_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SIZE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  input  logic              smm_active,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_off,
  input  logic [7:0]        cfg_wdata,
  input  logic [SIZE_W-1:0] size_mb,
  output logic [1:0]        tgt_sel,
  output logic              wr_block,
  output logic [7:0]        dram_units
);
  logic [ATTR_BYTES*8-1:0] attr_flat;
  logic [7:0]              smram;
  logic                    size_loaded;

  legacy_cfg_regs #(.SIZE_W(SIZE_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_off     (cfg_off),
    .cfg_wdata   (cfg_wdata),
    .size_mb     (size_mb),
    .attr_flat   (attr_flat),
    .smram       (smram),
    .dram_units  (dram_units),
    .size_loaded (size_loaded)
  );

  legacy_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .acc_addr   (acc_addr),
    .acc_write  (acc_write),
    .smm_active (smm_active),
    .attr_flat  (attr_flat),
    .smram      (smram),
    .tgt_sel    (tgt_sel),
    .wr_block   (wr_block)
  );
endmodule

// File: rtl/legacy_steer_chk.sv
module legacy_steer_chk
  import legacy_steer_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [ADDR_W-1:0]       acc_addr,
  input logic                    acc_write,
  input logic                    smm_active,
  input logic                    cfg_we,
  input logic [7:0]              cfg_off,
  input logic [1:0]              tgt_sel,
  input logic                    wr_block,
  input logic [ATTR_BYTES*8-1:0] attr_flat,
  input logic [7:0]              smram,
  input logic [7:0]              dram_units,
  input logic                    size_loaded
);
  logic cfg_hit;
  logic in_vga;
  assign cfg_hit = (cfg_off >= 8'(ATTR_BASE) && cfg_off < 8'(ATTR_BASE + ATTR_BYTES))
                   || (cfg_off == 8'(SMRAM_OFF));
  assign in_vga  = (acc_addr >= ADDR_W'(32'hA0000)) && (acc_addr < ADDR_W'(32'hC0000));

  assert_wr_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_block |-> (acc_write && tgt_sel == TGT_DRAM_RO));

  assert_above_1m_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_addr[ADDR_W-1:20] != '0) |-> (tgt_sel == TGT_DRAM && !wr_block));

  assert_vga_closed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vga && !smram[6] && !(smram[3] && smm_active)) |-> tgt_sel == TGT_PCI);

  assert_vga_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vga && (smram[6] || (smram[3] && smm_active))) |-> tgt_sel == TGT_DRAM);

  assert_foreign_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_hit) |=> ($stable(attr_flat) && $stable(smram)));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(attr_flat) && $stable(smram)));

  assert_size_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    size_loaded |=> (size_loaded && $stable(dram_units)));
endmodule

bind legacy_steer_top legacy_steer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .acc_addr    (acc_addr),
  .acc_write   (acc_write),
  .smm_active  (smm_active),
  .cfg_we      (cfg_we),
  .cfg_off     (cfg_off),
  .tgt_sel     (tgt_sel),
  .wr_block    (wr_block),
  .attr_flat   (attr_flat),
  .smram       (smram),
  .dram_units  (dram_units),
  .size_loaded (size_loaded)
);

// File: tb/tb_legacy_steer_top.sv
`timescale 1ns/1ps
module tb_legacy_steer_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] acc_addr;
  logic        acc_write;
  logic        smm_active;
  logic        cfg_we;
  logic [7:0]  cfg_off;
  logic [7:0]  cfg_wdata;
  logic [15:0] size_mb;
  logic [1:0]  tgt_sel;
  logic        wr_block;
  logic [7:0]  dram_units;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  legacy_steer_top dut (
    .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_write(acc_write),
    .smm_active(smm_active), .cfg_we(cfg_we), .cfg_off(cfg_off),
    .cfg_wdata(cfg_wdata), .size_mb(size_mb), .tgt_sel(tgt_sel),
    .wr_block(wr_block), .dram_units(dram_units)
  );

  // behavioural reference: a byte-addressed configuration space
  logic [7:0] m_cfg [0:255];
  int         m_units;
  bit         m_loaded;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) m_cfg[i] = 8'h00;
      m_cfg[8'h72] = 8'h02;
      m_units  = 0;
      m_loaded = 0;
    end else begin
      if (cfg_we && ((cfg_off >= 8'h59 && cfg_off <= 8'h5F) || cfg_off == 8'h72))
        m_cfg[cfg_off] = cfg_wdata;
      if (!m_loaded) begin
        m_units  = (int'(size_mb) / 8 > 255) ? 255 : int'(size_mb) / 8;
        m_loaded = 1;
      end
    end
  end

  function automatic int attr_of(logic [31:0] a);
    int k;
    if (a >= 32'hF0000) return (int'(m_cfg[8'h59]) >> 4) & 3;
    k = int'(a - 32'hC0000) / 32'h4000;
    return (int'(m_cfg[8'h5A + k/2]) >> (4 * (k % 2))) & 3;
  endfunction

  function automatic string region_tag(logic [31:0] a);
    if (a >= 32'h100000 || a < 32'hA0000) return "R2";
    if (a < 32'hC0000) return "R6";
    if (a < 32'hF0000) return "R3";
    return "R4";
  endfunction

  task automatic compare(string note);
    int exp_t;
    int exp_wb;
    int at;
    logic [31:0] a;
    a = acc_addr;
    exp_wb = 0;
    if (a >= 32'h100000 || a < 32'hA0000) exp_t = 0;
    else if (a < 32'hC0000)
      exp_t = (m_cfg[8'h72][6] || (m_cfg[8'h72][3] && smm_active)) ? 0 : 2;
    else begin
      at = attr_of(a);
      exp_t  = (at == 3) ? 0 : (at == 1) ? 1 : 2;
      exp_wb = (at == 1 && acc_write) ? 1 : 0;
    end
    checks++;
    if (int'(tgt_sel) != exp_t) begin
      errors++;
      $display("FAIL %s/%s addr=%h tgt_sel act=%0d exp=%0d", note, region_tag(a), a, tgt_sel, exp_t);
    end
    checks++;
    if (int'(wr_block) != exp_wb) begin
      errors++;
      $display("FAIL %s/R5 addr=%h wr_block act=%0d exp=%0d", note, a, wr_block, exp_wb);
    end
    checks++;
    if (int'(dram_units) != m_units) begin
      errors++;
      $display("FAIL %s/R9 dram_units act=%0d exp=%0d", note, dram_units, m_units);
    end
  endtask

  task automatic step(logic [31:0] a, logic w, logic s, logic we,
                      logic [7:0] off, logic [7:0] d, string note);
    @(negedge clk);
    acc_addr = a; acc_write = w; smm_active = s;
    cfg_we = we; cfg_off = off; cfg_wdata = d;
    #1;
    compare(note);
  endtask

  task automatic cfg_write(logic [7:0] off, logic [7:0] d, string note);
    step(32'hC0000, 1'b1, 1'b0, 1'b1, off, d, note);
  endtask

  task automatic sweep(string note);
    for (logic [31:0] a = 32'h98000; a <= 32'h104000; a += 32'h4000) begin
      step(a, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, note);
      step(a + 32'h3FFF, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00, note);
    end
  endtask

  task automatic do_reset(logic [15:0] sz);
    @(negedge clk);
    rst_n = 1'b0; size_mb = sz;
    cfg_we = 1'b0; acc_addr = 32'hC0000; acc_write = 1'b0; smm_active = 1'b1;
    #1;
    compare("R1 reset");
    step(32'hA0000, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, "R1 reset");
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200_000 * 4);
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b1; size_mb = 16'd100;
    acc_addr = '0; acc_write = 1'b0; smm_active = 1'b0;
    cfg_we = 1'b0; cfg_off = '0; cfg_wdata = '0;
    do_reset(16'd100);
    // R9: first edge loads 100/8 = 12
    step(32'h0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, "R9 load");
    // R1: reset mapping, whole window forwarded
    sweep("R1 reset map");
    // R2: outside the legacy window
    step(32'h0009FFFF, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, "R2 low");
    step(32'h00100000, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00, "R2 1MB");
    step(32'hFFFFFFFF, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, "R2 top");
    step(32'h800C0000, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, "R2 alias");
    // R8: same-cycle compare still expects old mapping
    step(32'hC0000, 1'b1, 1'b0, 1'b1, 8'h5A, 8'h31, "R8 write cycle");
    step(32'hC0000, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, "R8 after write");
    step(32'hC0000, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, "R5 ro read");
    step(32'hC4000, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, "R5 rw write");
    // R3/R4/R5: varied attribute patterns over every segment
    for (int p = 0; p < 6; p++) begin
      for (int b = 0; b < 7; b++)
        cfg_write(8'(8'h59 + b), 8'((p * 8'h37 + b * 8'h1B + p * b) & 8'hFF), "R3 program");
      sweep("R3/R4 pattern");
    end
    cfg_write(8'h59, 8'h30, "R4 program");
    step(32'hF0000, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, "R4 dram");
    cfg_write(8'h59, 8'h10, "R4 program");
    step(32'hFFFFF, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, "R4 ro write");
    step(32'hFFFFF, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, "R4 ro read");
    // R7: neighbouring offsets leave every result unchanged
    cfg_write(8'h58, 8'hFF, "R7 ignored");
    cfg_write(8'h60, 8'hFF, "R7 ignored");
    cfg_write(8'h71, 8'hFF, "R7 ignored");
    cfg_write(8'h73, 8'hFF, "R7 ignored");
    sweep("R7 after foreign writes");
    // R6: SMRAM window
    cfg_write(8'h72, 8'h08, "R6 program");
    step(32'hA0000, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, "R6 mode off");
    step(32'hBFFFF, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00, "R6 mode on");
    step(32'hB0000, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, "R6 mode off again");
    cfg_write(8'h72, 8'h40, "R6 program");
    step(32'hA8000, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, "R6 force open");
    cfg_write(8'h72, 8'h00, "R6 program");
    step(32'hA8000, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00, "R6 closed");
    // R9: later size changes are ignored
    size_mb = 16'd4000;
    step(32'h0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, "R9 hold");
    step(32'h0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, "R9 hold");
    // R9 clamp and exact limit; R1 after a second reset
    do_reset(16'd4096);
    step(32'h0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, "R9 clamp");
    sweep("R1 reset map again");
    do_reset(16'd2047);
    step(32'h0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, "R9 limit");
    do_reset(16'd7);
    step(32'h0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, "R9 small");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule